// File: doc/BRIEF.md
# Accumulator Byte ALU with Nibble Flags

This block is the arithmetic and logic datapath for a small accumulator machine. Each cycle it can take an operation code, the accumulator byte, a second operand byte and the current flag nibble. One clock later it presents the result byte, a strobe that says whether the result should be written back to the accumulator, and the updated flags. The combinational core computes the full eight-bit carry or borrow. It also computes a nibble carry or borrow and a subtract marker, which a later decimal-adjust step can use.

The operand selection, the register file and the instruction sequencing live outside the block. The caller raises `in_valid` for each operation it wants evaluated. While `in_valid` is low, the registered outputs keep their previous values. Flags travel as a four-bit vector, with bit 3 = Z (zero), bit 2 = N (subtract), bit 1 = H (nibble carry or borrow) and bit 0 = C (carry or borrow).

Top module: `acc_alu`

## Requirements
- R1: Reset (synchronous, active high) clears `res_q`, `wr_q`, `flags_q` and `valid_q`. An operation presented with `in_valid` high appears on the outputs after the next rising edge, and `valid_q` is high for that one cycle.
- R2: Op 0 (add) and op 1 (add with carry, where carry-in is `flags_in[0]`) write `acc + opnd + cin`. Z = result is zero, N = 0, H = carry out of bit 3, C = carry out of bit 7.
- R3: Op 2 (subtract) and op 3 (subtract with borrow, where borrow-in is `flags_in[0]`) write `acc - opnd - cin`. Z = result is zero, N = 1, H = low nibble of acc is less than (low nibble of opnd + cin), C = acc is less than (opnd + cin).
- R4: Op 4 (compare) sets all four flags exactly as op 2 would, and `wr_q` is 0.
- R5: Op 5 (AND), op 6 (OR) and op 7 (XOR) write the bitwise result. Z = result is zero, N = 0, C = 0. H = 1 for AND and H = 0 for OR and XOR.
- R6: Op 8 writes `opnd + 1` and op 9 writes `opnd - 1`. H = carry out of bit 3 for op 8, and H = borrow into bit 4 for op 9 (low nibble was 0). Z = result is zero, N = 1 only for op 9, and C is copied from `flags_in[0]`.
- R7: Op 10 writes the bitwise inverse of `acc`, sets N = 1 and H = 1, and keeps Z and C.
- R8: Op 11 forces C = 1 and op 12 inverts C. Both clear N and H, keep Z, and do not write a result.
- R9: Op codes 13 to 15 write nothing and pass `flags_in` through unchanged.
- R10: While `in_valid` is low, `res_q`, `wr_q` and `flags_q` keep their values and `valid_q` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Evaluate the presented operation this cycle |
| op | input | 4 | Operation code (see requirements) |
| acc | input | W (8) | Accumulator value |
| opnd | input | W (8) | Second operand byte |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| res_q | output | W (8) | Registered result byte |
| wr_q | output | 1 | Registered write-back enable for `res_q` |
| flags_q | output | 4 | Registered next flags {Z,N,H,C} |
| valid_q | output | 1 | High one cycle after an accepted operation |

## Verification
Every fault in the core shows up on the registered outputs one cycle after the operation that exposes it. The flag logic is the most likely place for a wrong nibble carry, a wrong borrow polarity or a dropped carry-in. Such a fault appears only for particular operand pairs, for example a low nibble of 0xF plus 1, or an operand equal to the accumulator with borrow-in set. For this reason the operand grid includes the 0x00 and 0xFF edges and is run with both carry-in values. A compare that wrongly writes back, or an increment that disturbs C, changes `wr_q` or `flags_q` on that same single cycle and nowhere else.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_CMP = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9,
    OP_CPL = 4'd10,
    OP_SCF = 4'd11,
    OP_CCF = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } alu_flags_t;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] r,
  output logic         hc,
  output logic         cy
);

  logic [W:0]   full;
  logic [NIB:0] low;
  logic [W:0]   cin_w;
  logic [NIB:0] cin_n;

  assign cin_w = {{W{1'b0}}, cin};
  assign cin_n = {{NIB{1'b0}}, cin};

  // A negative difference wraps, so the extra top bit doubles as the borrow
  always_comb begin
    if (sub) begin
      full = {1'b0, x} - {1'b0, y} - cin_w;
      low  = {1'b0, x[NIB-1:0]} - {1'b0, y[NIB-1:0]} - cin_n;
    end else begin
      full = {1'b0, x} + {1'b0, y} + cin_w;
      low  = {1'b0, x[NIB-1:0]} + {1'b0, y[NIB-1:0]} + cin_n;
    end
  end

  assign r  = full[W-1:0];
  assign cy = full[W];
  assign hc = low[NIB];

endmodule

// File: rtl/acc_alu_step.sv
module acc_alu_step #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] v,
  input  logic         down,
  output logic [W-1:0] r,
  output logic         hc
);

  localparam logic [W-1:0]   ONE   = {{(W-1){1'b0}}, 1'b1};
  localparam logic [NIB-1:0] NFULL = {NIB{1'b1}};
  localparam logic [NIB-1:0] NZERO = {NIB{1'b0}};

  always_comb begin
    if (down) begin
      r  = v - ONE;
      hc = (v[NIB-1:0] == NZERO);
    end else begin
      r  = v + ONE;
      hc = (v[NIB-1:0] == NFULL);
    end
  end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_sel_e   sel,
  output logic [W-1:0] r
);

  always_comb begin
    case (sel)
      LG_AND:  r = a & b;
      LG_OR:   r = a | b;
      LG_XOR:  r = a ^ b;
      default: r = '0;
    endcase
  end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  alu_flags_t      fin,
  output logic [W-1:0]    res,
  output logic            wr,
  output alu_flags_t      fout
);

  logic         as_sub, as_cin, as_h, as_c;
  logic [W-1:0] as_r;
  logic [W-1:0] st_r;
  logic         st_h;
  logic [W-1:0] lg_r;
  logic_sel_e   lg_sel;

  assign as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
  assign as_cin = ((op == OP_ADC) || (op == OP_SBC)) && fin.c;

  always_comb begin
    case (op)
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_AND;
    endcase
  end

  acc_alu_addsub #(.W(W), .NIB(NIB)) u_addsub (
    .x(a), .y(b), .cin(as_cin), .sub(as_sub),
    .r(as_r), .hc(as_h), .cy(as_c)
  );

  acc_alu_step #(.W(W), .NIB(NIB)) u_step (
    .v(b), .down(op == OP_DEC), .r(st_r), .hc(st_h)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .a(a), .b(b), .sel(lg_sel), .r(lg_r)
  );

  always_comb begin
    res  = a;
    wr   = 1'b0;
    fout = fin;
    case (op)
      OP_ADD, OP_ADC: begin
        res  = as_r;
        wr   = 1'b1;
        fout = '{z: (as_r == '0), n: 1'b0, h: as_h, c: as_c};
      end
      OP_SUB, OP_SBC: begin
        res  = as_r;
        wr   = 1'b1;
        fout = '{z: (as_r == '0), n: 1'b1, h: as_h, c: as_c};
      end
      OP_CMP: begin
        res  = as_r;
        wr   = 1'b0;
        fout = '{z: (as_r == '0), n: 1'b1, h: as_h, c: as_c};
      end
      OP_AND, OP_OR, OP_XOR: begin
        res  = lg_r;
        wr   = 1'b1;
        fout = '{z: (lg_r == '0), n: 1'b0, h: (op == OP_AND), c: 1'b0};
      end
      OP_INC, OP_DEC: begin
        res  = st_r;
        wr   = 1'b1;
        fout = '{z: (st_r == '0), n: (op == OP_DEC), h: st_h, c: fin.c};
      end
      OP_CPL: begin
        res  = ~a;
        wr   = 1'b1;
        fout = '{z: fin.z, n: 1'b1, h: 1'b1, c: fin.c};
      end
      OP_SCF: fout = '{z: fin.z, n: 1'b0, h: 1'b0, c: 1'b1};
      OP_CCF: fout = '{z: fin.z, n: 1'b0, h: 1'b0, c: ~fin.c};
      default: ;
    endcase
  end

  // R8: carry ops never request a write-back
  always_comb begin
    if ((op == OP_SCF) || (op == OP_CCF))
      p_carry_nowrite_r8: assert (!wr);
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [3:0]   op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  input  logic [3:0]   flags_in,
  output logic [W-1:0] res_q,
  output logic         wr_q,
  output logic [3:0]   flags_q,
  output logic         valid_q
);

  localparam int NIB = 4;

  logic [W-1:0]    res_c;
  logic            wr_c;
  alu_flags_t      fout_c;
  logic [OP_W-1:0] op_q;
  logic [3:0]      fin_q;

  acc_alu_core #(.W(W), .NIB(NIB)) u_core (
    .op(op), .a(acc), .b(opnd), .fin(alu_flags_t'(flags_in)),
    .res(res_c), .wr(wr_c), .fout(fout_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      wr_q    <= 1'b0;
      flags_q <= '0;
      valid_q <= 1'b0;
      op_q    <= '0;
      fin_q   <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        res_q   <= res_c;
        wr_q    <= wr_c;
        flags_q <= fout_c;
        op_q    <= op;
        fin_q   <= flags_in;
      end
    end
  end

  p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_q && op_q == OP_CMP) |-> (!wr_q && flags_q[2]));

  p_logic_clear_c_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_q && (op_q == OP_AND || op_q == OP_OR || op_q == OP_XOR))
      |-> (!flags_q[0] && !flags_q[2] && wr_q));

  p_incdec_keep_c_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_q && (op_q == OP_INC || op_q == OP_DEC)) |-> (flags_q[0] == fin_q[0]));

  p_unused_pass_r9: assert property (@(posedge clk) disable iff (rst)
    (valid_q && op_q > OP_CCF) |-> (!wr_q && flags_q == fin_q));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res_q) && $stable(flags_q) && $stable(wr_q) && !valid_q));

endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;

  localparam time CLK_P = 20ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] acc = '0;
  logic [7:0] opnd = '0;
  logic [3:0] flags_in = '0;
  logic [7:0] res_q;
  logic       wr_q;
  logic [3:0] flags_q;
  logic       valid_q;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  acc_alu #(.W(8)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .acc(acc),
    .opnd(opnd), .flags_in(flags_in), .res_q(res_q), .wr_q(wr_q),
    .flags_q(flags_q), .valid_q(valid_q)
  );

  function automatic string op_tag(input int o);
    case (o)
      0, 1:      return "R2";
      2, 3:      return "R3";
      4:         return "R4";
      5, 6, 7:   return "R5";
      8, 9:      return "R6";
      10:        return "R7";
      11, 12:    return "R8";
      default:   return "R9";
    endcase
  endfunction

  // returns {wr, res[7:0], Z, N, H, C}
  function automatic logic [12:0] model(input int o, input int a, input int b, input logic [3:0] f);
    int s, r, ci;
    logic z, n, h, c, w;
    ci = f[0];
    r = a; w = 0; z = f[3]; n = f[2]; h = f[1]; c = f[0];
    case (o)
      0, 1: begin
        if (o == 0) ci = 0;
        s = a + b + ci; r = s & 255; w = 1; n = 0;
        h = ((a & 15) + (b & 15) + ci) > 15; c = s > 255; z = (r == 0);
      end
      2, 3, 4: begin
        if (o != 3) ci = 0;
        r = (a - b - ci) & 255; w = (o != 4); n = 1;
        h = (a & 15) < ((b & 15) + ci); c = a < (b + ci); z = (r == 0);
      end
      5, 6, 7: begin
        r = (o == 5) ? (a & b) : (o == 6) ? (a | b) : (a ^ b);
        w = 1; z = (r == 0); n = 0; h = (o == 5); c = 0;
      end
      8: begin r = (b + 1) & 255; w = 1; z = (r == 0); n = 0; h = (b & 15) == 15; end
      9: begin r = (b + 255) & 255; w = 1; z = (r == 0); n = 1; h = (b & 15) == 0; end
      10: begin r = (~a) & 255; w = 1; n = 1; h = 1; end
      11: begin n = 0; h = 0; c = 1; end
      12: begin n = 0; h = 0; c = ~f[0]; end
      default: ;
    endcase
    return {w, r[7:0], z, n, h, c};
  endfunction

  task automatic run_vec(input int o, input int a, input int b, input logic [3:0] f);
    logic [12:0] exp;
    exp = model(o, a, b, f);
    @(negedge clk);
    in_valid = 1'b1; op = o[3:0]; acc = a[7:0]; opnd = b[7:0]; flags_in = f;
    @(posedge clk);
    #1;
    checks++;
    if (valid_q !== 1'b1 || wr_q !== exp[12] || flags_q !== exp[3:0] ||
        (exp[12] && res_q !== exp[11:4])) begin
      failures++;
      $display("FAIL %s op=%0d a=%02h b=%02h f=%b: got v=%b wr=%b res=%02h fl=%b exp wr=%b res=%02h fl=%b",
               op_tag(o), o, a, b, f, valid_q, wr_q, res_q, flags_q, exp[12], exp[11:4], exp[3:0]);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic sweep(input int lo, input int hi);
    for (int o = lo; o <= hi; o++)
      for (int ai = 0; ai <= 37; ai++)
        for (int bi = 0; bi <= 24; bi++)
          for (int ci = 0; ci < 2; ci++) begin
            int a, b;
            a = (ai == 37) ? 255 : ai * 7;
            b = (bi == 24) ? 255 : bi * 11;
            run_vec(o, a, b, {a[0], b[0], a[1], ci[0]});
          end
  endtask

  task automatic t_reset;  // R1
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (res_q !== 8'h00 || wr_q !== 1'b0 || flags_q !== 4'h0 || valid_q !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: got res=%02h wr=%b fl=%b v=%b exp all zero", res_q, wr_q, flags_q, valid_q);
    end
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_add;  // R2
    run_vec(0, 8'hFF, 8'h01, 4'h0);
    run_vec(1, 8'h0F, 8'h00, 4'h1);
    run_vec(1, 8'hFF, 8'hFF, 4'h1);
    sweep(0, 1);
  endtask

  task automatic t_sub;  // R3
    run_vec(2, 8'h10, 8'h01, 4'h0);
    run_vec(3, 8'h42, 8'h42, 4'h1);
    run_vec(3, 8'h00, 8'hFF, 4'h1);
    sweep(2, 3);
  endtask

  task automatic t_cmp;  // R4
    run_vec(4, 8'h42, 8'h42, 4'h1);
    sweep(4, 4);
  endtask

  task automatic t_logic;  // R5
    run_vec(5, 8'hF0, 8'h0F, 4'hF);
    run_vec(7, 8'hAA, 8'hAA, 4'h1);
    sweep(5, 7);
  endtask

  task automatic t_incdec;  // R6
    run_vec(8, 8'h00, 8'hFF, 4'h1);
    run_vec(9, 8'h00, 8'h01, 4'h0);
    run_vec(9, 8'h00, 8'h00, 4'h1);
    sweep(8, 9);
  endtask

  task automatic t_cpl;  // R7
    run_vec(10, 8'h00, 8'h00, 4'b1001);
    sweep(10, 10);
  endtask

  task automatic t_carry;  // R8
    run_vec(11, 8'h00, 8'h00, 4'b1110);
    run_vec(12, 8'h00, 8'h00, 4'b0111);
    sweep(11, 12);
  endtask

  task automatic t_unused;  // R9
    sweep(13, 15);
  endtask

  task automatic t_hold;  // R10
    logic [7:0] r0;
    logic [3:0] f0;
    logic       w0;
    run_vec(0, 8'h12, 8'h34, 4'h0);
    r0 = res_q; f0 = flags_q; w0 = wr_q;
    @(negedge clk);
    in_valid = 1'b0; op = 4'd2; acc = 8'h00; opnd = 8'hFF; flags_in = 4'hF;
    repeat (3) begin
      @(posedge clk);
      #1;
      checks++;
      if (res_q !== r0 || flags_q !== f0 || wr_q !== w0 || valid_q !== 1'b0) begin
        failures++;
        $display("FAIL R10 hold: got res=%02h fl=%b wr=%b v=%b exp res=%02h fl=%b wr=%b v=0",
                 res_q, flags_q, wr_q, valid_q, r0, f0, w0);
      end
    end
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_incdec();
    t_cpl();
    t_carry();
    t_unused();
    t_hold();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule